// File: doc/BRIEF.md
# Phase Quantizer

This block turns one row of complex pixel sums into phase-only pixels. A line engine accumulates a real and an imaginary sum for every pixel unit of a row. It then pulses `row_start` and holds those sums steady while `busy` is high. The quantizer walks the units one per cycle in x order and computes one shift amount for the whole row from the largest magnitude. It scales both components of each pixel down to 5-bit two's-complement values with that shift. The two 5-bit values are joined into a 10-bit address into a precomputed arctangent table, which gives an 8-bit phase.

Each phase goes into a small output FIFO. The FIFO feeds the frame-buffer side through a valid/ready handshake. When that FIFO is full, the walk waits in place, so back-pressure never loses a pixel. A one-cycle `row_done` pulse marks the point where the last unit's phase has entered the FIFO. At the same point `busy` drops and the engine may present the next row.

Top module: `phase_quantizer`

## Requirements
- R1: After reset, `busy`, `out_valid` and `row_done` are low.
- R2: When a row is accepted, one shift `s` is chosen for the whole row. `s` is the smallest value for which every real and every imaginary magnitude of the row, shifted right by `s`, is at most 15. Magnitudes are taken as |v|, so -16 needs `s` of at least 1.
- R3: Each component is normalized by an arithmetic right shift by `s` (rounding toward minus infinity) and kept as a 5-bit two's-complement value. The table address is `{re5, im5}`: the real part in bits 9:5 and the imaginary part in bits 4:0.
- R4: The phase code is round(atan2(im5, re5) * 256 / 2π) modulo 256, to within one code. Pixels on the axes or on a diagonal are exact: positive real gives 0, positive imaginary 64, negative real 128, negative imaginary 192, and re5 = im5 > 0 gives 32. A zero input (re5 = im5 = 0) gives 0.
- R5: A `row_start` seen while idle raises `busy` on the next edge. From the edge after that, one pixel per cycle enters the FIFO, in unit order 0 to N-1, whenever the FIFO has room.
- R6: While the FIFO is full, the unit index holds. Every unit of a row reaches the output exactly once, however long `out_ready` stays low.
- R7: `row_done` is high for exactly one cycle: the cycle after the last unit's phase is written into the FIFO. `busy` falls on that same edge.
- R8: A `row_start` asserted while `busy` is high is ignored. It does not change the row's shift, its order or its length.
- R9: `out_valid` is high exactly when the FIFO holds a phase. A phase is consumed on a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_phase` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| row_start | input | 1 | Request to quantize the row on `row_re`/`row_im` |
| row_re | input | NUM_UNITS*SUM_W | Real sums, unit u at bits [u*SUM_W +: SUM_W], signed |
| row_im | input | NUM_UNITS*SUM_W | Imaginary sums, same packing, signed |
| busy | output | 1 | Row in progress; sums must stay stable |
| out_valid | output | 1 | FIFO head holds a phase |
| out_ready | input | 1 | Frame-buffer side accepts the head phase |
| out_phase | output | PHASE_W | Phase code, 256 codes per full turn |
| row_done | output | 1 | One-cycle pulse after the last pixel of a row is queued |

## Verification
The stimulus aims at the shift boundaries: rows peaking at exactly 15, at exactly 16 or -16, and at the most negative 16-bit value. A design that tests the signed value instead of the magnitude, or that gets the edge of the shift search wrong, would either wrap these values to the wrong sign or throw away a bit it did not need to. Rows built from axis points, diagonal points and a zero pixel pin down exact phase codes. A swapped address field or a lost sign would rotate or mirror those phases. A row is also run with `out_ready` held low far past the FIFO depth, and `row_start` is pulsed in the middle of a row. A walk that keeps advancing when the FIFO is full would drop pixels, and a start that is not ignored would restart or rescale the row. Both show up as a short or wrong pixel stream.

// File: rtl/phq_pkg.sv
package phq_pkg;

  // Angle unit inside the table builder: 1/65536 of a full turn.
  localparam int ANG_BITS    = 16;
  localparam int CORDIC_ITER = 14;
  localparam int PRE_SCALE   = 4096;

  // atan(2^-i) expressed in 1/65536 of a turn
  function automatic int step_angle(input int i);
    case (i)
      0:       return 8192;
      1:       return 4836;
      2:       return 2555;
      3:       return 1297;
      4:       return 651;
      5:       return 326;
      6:       return 163;
      7:       return 81;
      8:       return 41;
      9:       return 20;
      10:      return 10;
      11:      return 5;
      12:      return 3;
      13:      return 1;
      default: return 0;
    endcase
  endfunction

  // Phase code for a table address {re, im}, both norm_w-bit two's complement.
  function automatic int atan_code(input int addr, input int norm_w, input int phase_w);
    int span, half, re, im, x, y, z, xs, ys;
    span = 1 << norm_w;
    half = 1 << (norm_w - 1);
    re = (addr >> norm_w) & (span - 1);
    im = addr & (span - 1);
    if (re >= half) re = re - span;
    if (im >= half) im = im - span;
    if (re == 0 && im == 0) return 0;
    x = re * PRE_SCALE;
    y = im * PRE_SCALE;
    z = 0;
    if (x < 0) begin
      x = -x;
      y = -y;
      z = 1 << (ANG_BITS - 1);
    end
    for (int i = 0; i < CORDIC_ITER; i++) begin
      xs = x >>> i;
      ys = y >>> i;
      if (y > 0) begin
        x = x + ys;
        y = y - xs;
        z = z + step_angle(i);
      end else begin
        x = x - ys;
        y = y + xs;
        z = z - step_angle(i);
      end
    end
    return ((z + (1 << (ANG_BITS - 1 - phase_w))) >>> (ANG_BITS - phase_w)) & ((1 << phase_w) - 1);
  endfunction

endpackage

// File: rtl/phq_row_scale.sv
module phq_row_scale #(
  parameter int NUM_UNITS = 8,
  parameter int SUM_W     = 16,
  parameter int NORM_W    = 5,
  localparam int MAG_W    = SUM_W + 1,
  localparam int SHIFT_W  = $clog2(SUM_W + 1)
) (
  input  logic [NUM_UNITS*SUM_W-1:0] row_re,
  input  logic [NUM_UNITS*SUM_W-1:0] row_im,
  output logic [SHIFT_W-1:0]         row_shift
);

  localparam int LIMIT = 1 << (NORM_W - 1);

  logic [MAG_W-1:0] mag_re [NUM_UNITS];
  logic [MAG_W-1:0] mag_im [NUM_UNITS];
  logic [MAG_W-1:0] peak;

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_mag
      logic signed [MAG_W-1:0] ext_re;
      logic signed [MAG_W-1:0] ext_im;
      assign ext_re = $signed({row_re[u*SUM_W+SUM_W-1], row_re[u*SUM_W +: SUM_W]});
      assign ext_im = $signed({row_im[u*SUM_W+SUM_W-1], row_im[u*SUM_W +: SUM_W]});
      assign mag_re[u] = ext_re[MAG_W-1] ? MAG_W'(-ext_re) : MAG_W'(ext_re);
      assign mag_im[u] = ext_im[MAG_W-1] ? MAG_W'(-ext_im) : MAG_W'(ext_im);
    end
  endgenerate

  always_comb begin
    peak = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (mag_re[u] > peak) peak = mag_re[u];
      if (mag_im[u] > peak) peak = mag_im[u];
    end
  end

  // Smallest shift that brings the peak under the 5-bit signed limit.
  always_comb begin
    row_shift = SHIFT_W'(SUM_W);
    for (int s = SUM_W; s >= 0; s--) begin
      if ((peak >> s) < MAG_W'(LIMIT)) row_shift = SHIFT_W'(s);
    end
  end

endmodule

// File: rtl/phq_atan_rom.sv
module phq_atan_rom #(
  parameter int NORM_W  = 5,
  parameter int PHASE_W = 8,
  localparam int ADDR_W = 2 * NORM_W,
  localparam int ENTRIES = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [PHASE_W-1:0] phase
);

  logic [PHASE_W-1:0] table_w [ENTRIES];

  generate
    for (genvar a = 0; a < ENTRIES; a++) begin : g_entry
      localparam int CODE = phq_pkg::atan_code(a, NORM_W, PHASE_W);
      assign table_w[a] = PHASE_W'(CODE);
    end
  endgenerate

  assign phase = table_w[addr];

endmodule

// File: rtl/phq_out_fifo.sv
module phq_out_fifo #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             rd_en;

  assign full     = (count_q == CNT_W'(DEPTH));
  assign rd_valid = (count_q != '0);
  assign rd_en    = rd_valid && rd_ready;
  assign rd_data  = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (wr_en) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count_q < CNT_W'(DEPTH))) else $error("write into full FIFO"); // R6

  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))) else $error("head moved while stalled"); // R9

endmodule

// File: rtl/phase_quantizer.sv
module phase_quantizer #(
  parameter int NUM_UNITS  = 8,
  parameter int SUM_W      = 16,
  parameter int NORM_W     = 5,
  parameter int PHASE_W    = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int SHIFT_W   = $clog2(SUM_W + 1),
  localparam int ADDR_W    = 2 * NORM_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       row_start,
  input  logic [NUM_UNITS*SUM_W-1:0] row_re,
  input  logic [NUM_UNITS*SUM_W-1:0] row_im,
  output logic                       busy,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [PHASE_W-1:0]         out_phase,
  output logic                       row_done
);

  logic               busy_q, busy_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic               done_q, done_d;

  logic [SHIFT_W-1:0] row_shift;
  logic               fifo_full;
  logic               push;
  logic               last;

  logic signed [SUM_W-1:0] sel_re, sel_im;
  logic signed [SUM_W-1:0] scaled_re, scaled_im;
  logic [ADDR_W-1:0]       lut_addr;
  logic [PHASE_W-1:0]      lut_phase;

  // Row-wide shift, evaluated on the cycle the row is accepted
  phq_row_scale #(
    .NUM_UNITS (NUM_UNITS),
    .SUM_W     (SUM_W),
    .NORM_W    (NORM_W)
  ) u_scale (
    .row_re    (row_re),
    .row_im    (row_im),
    .row_shift (row_shift)
  );

  // Unit multiplexer and normalization
  always_comb begin
    sel_re    = $signed(row_re[int'(idx_q)*SUM_W +: SUM_W]);
    sel_im    = $signed(row_im[int'(idx_q)*SUM_W +: SUM_W]);
    scaled_re = sel_re >>> shift_q;
    scaled_im = sel_im >>> shift_q;
    lut_addr  = {scaled_re[NORM_W-1:0], scaled_im[NORM_W-1:0]};
  end

  phq_atan_rom #(
    .NORM_W  (NORM_W),
    .PHASE_W (PHASE_W)
  ) u_rom (
    .addr  (lut_addr),
    .phase (lut_phase)
  );

  assign push = busy_q && !fifo_full;
  assign last = (idx_q == IDX_W'(NUM_UNITS - 1));

  phq_out_fifo #(
    .WIDTH (PHASE_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (push),
    .wr_data  (lut_phase),
    .full     (fifo_full),
    .rd_valid (out_valid),
    .rd_ready (out_ready),
    .rd_data  (out_phase)
  );

  // Walk control: next state
  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (row_start) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        shift_d = row_shift;
      end
    end else if (push) begin
      done_d = last;
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + 1'b1;
    end
  end

  // Walk control: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      done_q  <= done_d;
    end
  end

  assign busy     = busy_q;
  assign row_done = done_q;

  AST_INDEX_HOLDS_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fifo_full) |=> (busy_q && $stable(idx_q))) else $error("index moved on full FIFO"); // R6

  AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !last) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1))) else $error("unit order broken"); // R5

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && row_start) |=> $stable(shift_q)) else $error("shift reloaded mid-row"); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !row_done) else $error("row_done longer than one cycle"); // R7

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> !busy) else $error("row_done while busy"); // R7

endmodule

// File: tb/phase_quantizer_tb.sv
module phase_quantizer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int SW    = 16;
  localparam int DEPTH = 4;

  logic            clk;
  logic            rst_n;
  logic            row_start;
  logic [N*SW-1:0] row_re;
  logic [N*SW-1:0] row_im;
  logic            busy;
  logic            out_valid;
  logic            out_ready;
  logic [7:0]      out_phase;
  logic            row_done;

  int checks = 0;
  int errors = 0;
  int re_a [N];
  int im_a [N];
  int ready_mode = 0;  // 0 always ready, 1 never, 2 random
  int popped = 0;

  // reference model state
  bit m_busy;
  int m_idx;
  int m_shift;
  bit m_done;
  int q_code [$];
  bit q_exact [$];

  phase_quantizer #(
    .NUM_UNITS  (N),
    .SUM_W      (SW),
    .NORM_W     (5),
    .PHASE_W    (8),
    .FIFO_DEPTH (DEPTH)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_start (row_start),
    .row_re    (row_re),
    .row_im    (row_im),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_phase (out_phase),
    .row_done  (row_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R2: smallest shift bringing every magnitude to 15 or less
  function automatic int ref_shift();
    int mx, s;
    mx = 0;
    for (int u = 0; u < N; u++) begin
      if (iabs(re_a[u]) > mx) mx = iabs(re_a[u]);
      if (iabs(im_a[u]) > mx) mx = iabs(im_a[u]);
    end
    s = 0;
    while ((mx >> s) > 15) s++;
    return s;
  endfunction

  // R4: rounded phase of the normalized pair
  function automatic int ref_phase(input int r, input int i);
    real a;
    int c;
    if (r == 0 && i == 0) return 0;
    a = $atan2(real'(i), real'(r));
    c = int'(a * 256.0 / (2.0 * 3.14159265358979));
    return ((c % 256) + 256) % 256;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy  <= 1'b0;
      m_idx   <= 0;
      m_shift <= 0;
      m_done  <= 1'b0;
      q_code.delete();
      q_exact.delete();
    end else begin
      bit pop, push, old_busy;
      int r5, i5;
      old_busy = m_busy;
      pop  = (q_code.size() > 0) && out_ready;
      push = m_busy && (q_code.size() < DEPTH);
      if (pop) begin
        void'(q_code.pop_front());
        void'(q_exact.pop_front());
      end
      m_done = 1'b0;
      if (push) begin
        r5 = re_a[m_idx] >>> m_shift;   // R3 floor shift
        i5 = im_a[m_idx] >>> m_shift;
        q_code.push_back(ref_phase(r5, i5));
        q_exact.push_back((r5 == 0) || (i5 == 0) || (r5 == i5));
        if (m_idx == N - 1) begin
          m_done = 1'b1;
          m_busy = 1'b0;
        end else begin
          m_idx = m_idx + 1;
        end
      end
      if (!old_busy && row_start) begin
        m_busy  = 1'b1;
        m_idx   = 0;
        m_shift = ref_shift();
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) popped++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int d;
    check(out_valid == (q_code.size() > 0), "R9 out_valid", int'(out_valid), int'(q_code.size() > 0));
    check(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
    check(row_done == m_done, "R7 row_done", int'(row_done), int'(m_done));
    if (out_valid && q_code.size() > 0) begin
      d = (int'(out_phase) - q_code[0] + 256) % 256;
      if (q_exact[0]) check(d == 0, "R4 exact phase (R2 R3 scaling)", int'(out_phase), q_code[0]);
      else check(d == 0 || d == 1 || d == 255, "R4 phase within one code (R2 R3 scaling)",
                 int'(out_phase), q_code[0]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'b0;
      default: out_ready = ($urandom_range(0, 3) != 0);
    endcase
  endtask

  task automatic set_row(input int re_v [N], input int im_v [N]);
    for (int u = 0; u < N; u++) begin
      re_a[u] = re_v[u];
      im_a[u] = im_v[u];
      row_re[u*SW +: SW] = SW'(re_v[u]);
      row_im[u*SW +: SW] = SW'(im_v[u]);
    end
  endtask

  task automatic start_row();
    row_start = 1'b1;
    step();
    row_start = 1'b0;
  endtask

  task automatic drain();
    int prev_mode;
    prev_mode = ready_mode;
    ready_mode = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      if (!busy && !out_valid && q_code.size() == 0) break;
    end
    ready_mode = prev_mode;
  endtask

  task automatic random_row(input int lim);
    int rv [N];
    int iv [N];
    for (int u = 0; u < N; u++) begin
      rv[u] = $urandom_range(0, 2 * lim) - lim;
      iv[u] = $urandom_range(0, 2 * lim) - lim;
    end
    set_row(rv, iv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0;
    row_start = 1'b0;
    out_ready = 1'b1;
    row_re = '0;
    row_im = '0;
    for (int u = 0; u < N; u++) begin
      re_a[u] = 0;
      im_a[u] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !out_valid && !row_done, "R1 reset outputs", int'({busy, out_valid, row_done}), 0);
    rst_n = 1'b1;
    step();

    // Axes, diagonal and zero pixel: shift 3, exact codes 0 64 128 192 0 32 (R4)
    set_row('{100, 0, -100, 0, 0, 70, -50, 3}, '{0, 100, 0, -100, 0, 70, 30, -7});
    start_row();
    drain();

    // Peak of exactly 15: no shift (R2)
    set_row('{15, -15, 1, -1, 7, 0, -3, 12}, '{0, 5, -15, 1, -7, 2, 15, -12});
    start_row();
    drain();

    // Magnitude 16 and -16 force shift 1 (R2, R3)
    set_row('{-16, 16, 9, -9, 3, 0, -1, 1}, '{16, -16, -9, 9, 0, -3, 1, -1});
    start_row();
    drain();

    // Most negative sum: shift 12 (R2, R3)
    set_row('{-32768, 32767, 4096, -4096, 0, 100, -4095, 2048}, '{0, -32768, 4096, 0, -4096, -100, 4095, -2048});
    start_row();
    drain();

    // R6: stall far beyond the FIFO depth, then release; all N pixels must come out
    random_row(500);
    base = popped;
    ready_mode = 1;
    start_row();
    for (int k = 0; k < 20; k++) step();
    check(busy == 1'b1, "R6 walk waits on full FIFO", int'(busy), 1);
    ready_mode = 0;
    drain();
    check(popped - base == N, "R6 pixel count after stall", popped - base, N);

    // R8: start pulses in the middle of a row are ignored
    random_row(3000);
    base = popped;
    start_row();
    step();
    row_start = 1'b1;
    step();
    step();
    row_start = 1'b0;
    drain();
    check(popped - base == N, "R8 row length unchanged", popped - base, N);

    // R5 R7: back-to-back rows, next start on the cycle busy falls
    random_row(20);
    start_row();
    for (int k = 0; k < 40; k++) begin
      step();
      if (row_done) break;
    end
    random_row(200);
    start_row();
    drain();

    // Random rows with random back-pressure
    ready_mode = 2;
    for (int r = 0; r < 30; r++) begin
      case (r % 3)
        0:       random_row(15);
        1:       random_row(900);
        default: random_row(32767);
      endcase
      start_row();
      for (int k = 0; k < 60; k++) begin
        step();
        if (!busy) break;
      end
    end
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule